// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by reading descriptors from a two-level translation table in memory. Software programs the first-level table base and raises an enable. After that, each accepted request starts a walk. The walker reads one first-level descriptor. If that descriptor points to a second-level table, it reads one second-level descriptor. The result is either a refill record (physical address, page size, attribute bits) sent to a TLB, or a translation fault.

The walker handles one request at a time. Its state machine has five states:
- `ST_IDLE` waits for a request. It moves to `ST_L1_READ` when a request is accepted.
- `ST_L1_READ` issues the first-level read and waits for its response. On the response it moves to `ST_DONE` for a 1M or 16M block, to `ST_L2_READ` for a table pointer, or to `ST_FAULT` for an invalid descriptor.
- `ST_L2_READ` issues the second-level read. On the response it moves to `ST_DONE` for a 4K or 64K page, or to `ST_FAULT` for an invalid descriptor.
- `ST_DONE` and `ST_FAULT` each last one cycle and then return to `ST_IDLE`.

Software fills the tables with the 16M and 64K mappings repeated 16 times. The walker decodes such a mapping from whichever copy the address indexes. A fault sets a sticky flag and captures the faulting address. Both are held until software writes a one to clear them.

Top module: `ptw_walker`

## Requirements
- R1: The base is sampled when `cfg_enable` rises. If its bits 13:0 are not all zero, `base_err` is 1 and `req_ready` stays 0. With an aligned base, `req_ready` is 1 while idle and enabled.
- R2: The first-level read address is {base[31:14], va[31:20], 2'b00}. A walk that ends at the first level makes exactly one memory read.
- R3: A first-level table pointer causes a second read at {desc[31:10], va[19:12], 2'b00}, so the walk makes exactly two reads.
- R4: First-level type bits 1:0 decode as follows: 01 is a table pointer; 10 is a 1M section when bit 18 is 0 and a 16M supersection when bit 18 is 1; 00 and 11 are faults.
- R5: A section gives pa = {desc[31:20], va[19:0]} with refill_size 2 (1M).
- R6: A supersection gives pa = {desc[31:24], va[23:0]} with refill_size 3 (16M). The result is the same from any of its 16 copies.
- R7: Second-level type bits 1:0 decode as follows. 01 is a 64K large page: pa = {desc[31:16], va[15:0]}, refill_size 1. 10 or 11 is a 4K small page: pa = {desc[31:12], va[11:0]}, refill_size 0.
- R8: `refill_attr` carries bits 11:2 of the descriptor that ended the walk, and `refill_va` carries the request address.
- R9: A second-level descriptor with type 00, or an invalid first-level descriptor, produces a one-cycle `walk_fault` and no `refill_valid`.
- R10: `fault_sticky` is set the cycle after a fault and `fault_addr` captures that walk's address. Later faults do not change `fault_addr` while the flag is set. A cycle with `fault_clr` = 1 clears the flag.
- R11: After a request is accepted, `req_ready` stays 0 until the walk returns to idle. `refill_valid` is a one-cycle pulse.
- R12: While `mem_rd_valid` is 1 and the read is not yet accepted, `mem_rd_addr` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Walker enable; its rising edge samples the base |
| cfg_base | input | 32 | First-level table base address |
| base_err | output | 1 | Enabled with a base that is not 16 KB aligned |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker accepts a request |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor address |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| refill_valid | output | 1 | One-cycle refill record for the TLB |
| refill_va | output | 32 | Virtual address of the refill |
| refill_pa | output | 32 | Translated physical address |
| refill_size | output | 2 | Page size: 0=4K, 1=64K, 2=1M, 3=16M |
| refill_attr | output | 10 | Descriptor bits 11:2 |
| walk_fault | output | 1 | One-cycle translation fault pulse |
| fault_clr | input | 1 | Write-one clear of the sticky fault |
| fault_sticky | output | 1 | Sticky fault flag |
| fault_addr | output | 32 | Captured faulting address |

## Verification
The assertions check these rules on every cycle:
- A bad base always blocks requests.
- A stalled memory read keeps its address.
- Read addresses are word aligned.
- Refill and fault never occur together, and each is a single pulse.
- Only one walk is in flight.
- The captured fault address holds until cleared.

The translation arithmetic itself can only be shown by the bench's scenarios:
- The merge of descriptor and address bits for all four page sizes.
- Decoding from every one of the 16 copies.
- The exact descriptor addresses and read counts.
- Fault capture, overwrite protection and clear ordering.
- Behaviour under a stalling memory port.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W      = 32;
    localparam int ATTR_W      = 10;
    localparam int ATTR_LSB    = 2;
    localparam int BASE_ALIGN  = 14;
    localparam int L1_IDX_LSB  = 20;
    localparam int L2_IDX_LSB  = 12;
    localparam int L2_BASE_LSB = 10;
    localparam int SUPER_BIT   = 18;
    localparam int SUPER_LSB   = 24;
    localparam int SECT_LSB    = 20;
    localparam int LARGE_LSB   = 16;
    localparam int SMALL_LSB   = 12;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_READ,
        ST_L2_READ,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        pg_size_e          size;
        logic [ATTR_W-1:0] attr;
    } xlat_t;

    // Descriptor base bits above lsb, virtual offset bits below it.
    function automatic logic [ADDR_W-1:0] merge_pa(
        input logic [ADDR_W-1:0] desc,
        input logic [ADDR_W-1:0] va,
        input int                lsb
    );
        logic [ADDR_W-1:0] hi_mask;
        hi_mask = {ADDR_W{1'b1}} << lsb;
        return (desc & hi_mask) | (va & ~hi_mask);
    endfunction

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output logic              is_table,
    output logic              is_fault,
    output logic [ADDR_W-1:0] l2_addr,
    output xlat_t             leaf
);

    always_comb begin
        is_table  = 1'b0;
        is_fault  = 1'b0;
        leaf.pa   = '0;
        leaf.size = PG_1M;
        leaf.attr = desc[ATTR_LSB +: ATTR_W];
        l2_addr   = {desc[ADDR_W-1:L2_BASE_LSB], va[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
        unique case (desc[1:0])
            2'b01: is_table = 1'b1;
            2'b10: begin
                if (desc[SUPER_BIT]) begin
                    leaf.pa   = merge_pa(desc, va, SUPER_LSB);
                    leaf.size = PG_16M;
                end else begin
                    leaf.pa   = merge_pa(desc, va, SECT_LSB);
                    leaf.size = PG_1M;
                end
            end
            default: is_fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output logic              is_fault,
    output xlat_t             leaf
);

    always_comb begin
        is_fault  = 1'b0;
        leaf.attr = desc[ATTR_LSB +: ATTR_W];
        leaf.pa   = merge_pa(desc, va, SMALL_LSB);
        leaf.size = PG_4K;
        unique case (desc[1:0])
            2'b00: is_fault = 1'b1;
            2'b01: begin
                leaf.pa   = merge_pa(desc, va, LARGE_LSB);
                leaf.size = PG_64K;
            end
            default: begin
                leaf.pa   = merge_pa(desc, va, SMALL_LSB);
                leaf.size = PG_4K;
            end
        endcase
    end

endmodule

// File: rtl/ptw_fault_reg.sv
module ptw_fault_reg
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr,
    output logic              sticky,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky <= 1'b0;
            addr   <= '0;
        end else if (set && (!sticky || clr)) begin
            sticky <= 1'b1;
            addr   <= set_addr;
        end else if (clr) begin
            sticky <= 1'b0;
        end
    end

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        sticky && !clr |=> sticky && $stable(addr)); // R10

    AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set |=> !sticky); // R10

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [31:0]       cfg_base,
    output logic              base_err,
    input  logic              req_valid,
    input  logic [31:0]       req_va,
    output logic              req_ready,
    output logic              mem_rd_valid,
    output logic [31:0]       mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              refill_valid,
    output logic [31:0]       refill_va,
    output logic [31:0]       refill_pa,
    output logic [1:0]        refill_size,
    output logic [9:0]        refill_attr,
    output logic              walk_fault,
    input  logic              fault_clr,
    output logic              fault_sticky,
    output logic [31:0]       fault_addr
);

    walk_state_e       state_q, state_d;
    logic              issued_q;
    logic              en_q, base_ok_q;
    logic [ADDR_W-1:0] base_q, va_q, l2_addr_q;
    xlat_t             result_q;

    logic              l1_table, l1_fault, l2_fault;
    logic [ADDR_W-1:0] l1_next;
    xlat_t             l1_leaf, l2_leaf;
    logic              rsp_here, rd_fire, req_fire;

    ptw_l1_decode u_l1_dec (
        .desc     (mem_rsp_data),
        .va       (va_q),
        .is_table (l1_table),
        .is_fault (l1_fault),
        .l2_addr  (l1_next),
        .leaf     (l1_leaf)
    );

    ptw_l2_decode u_l2_dec (
        .desc     (mem_rsp_data),
        .va       (va_q),
        .is_fault (l2_fault),
        .leaf     (l2_leaf)
    );

    ptw_fault_reg u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (walk_fault),
        .set_addr (va_q),
        .clr      (fault_clr),
        .sticky   (fault_sticky),
        .addr     (fault_addr)
    );

    assign rsp_here = issued_q && mem_rsp_valid;
    assign rd_fire  = mem_rd_valid && mem_rd_ready;
    assign req_fire = req_valid && req_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_fire) state_d = ST_L1_READ;
            ST_L1_READ: if (rsp_here) begin
                            if (l1_fault)      state_d = ST_FAULT;
                            else if (l1_table) state_d = ST_L2_READ;
                            else               state_d = ST_DONE;
                        end
            ST_L2_READ: if (rsp_here) state_d = l2_fault ? ST_FAULT : ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            issued_q  <= 1'b0;
            en_q      <= 1'b0;
            base_ok_q <= 1'b0;
            base_q    <= '0;
            va_q      <= '0;
            l2_addr_q <= '0;
            result_q  <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= cfg_enable;
            if (cfg_enable && !en_q) begin
                base_q    <= cfg_base;
                base_ok_q <= (cfg_base[BASE_ALIGN-1:0] == '0);
            end else if (!cfg_enable) begin
                base_ok_q <= 1'b0;
            end
            if (state_d != state_q)
                issued_q <= 1'b0;
            else if (rd_fire)
                issued_q <= 1'b1;
            if (req_fire)
                va_q <= req_va;
            if (state_q == ST_L1_READ && rsp_here) begin
                result_q  <= l1_leaf;
                l2_addr_q <= l1_next;
            end
            if (state_q == ST_L2_READ && rsp_here)
                result_q <= l2_leaf;
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE) && en_q && base_ok_q;
        base_err     = en_q && !base_ok_q;
        mem_rd_valid = ((state_q == ST_L1_READ) || (state_q == ST_L2_READ)) && !issued_q;
        mem_rd_addr  = (state_q == ST_L2_READ) ? l2_addr_q
                     : {base_q[ADDR_W-1:BASE_ALIGN], va_q[ADDR_W-1:L1_IDX_LSB], 2'b00};
        refill_valid = (state_q == ST_DONE);
        walk_fault   = (state_q == ST_FAULT);
        refill_va    = va_q;
        refill_pa    = result_q.pa;
        refill_size  = result_q.size;
        refill_attr  = result_q.attr;
    end

    AST_BAD_BASE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        base_err |-> !req_ready); // R1

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R12

    AST_NO_REFILL_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(refill_valid && walk_fault)); // R9

    AST_REFILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |=> !refill_valid); // R11

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R11

endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

    localparam logic [31:0] BASE   = 32'h0010_0000;
    localparam logic [31:0] L2BASE = 32'h0020_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [31:0] cfg_base = '0;
    logic        base_err;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        refill_valid;
    logic [31:0] refill_va, refill_pa;
    logic [1:0]  refill_size;
    logic [9:0]  refill_attr;
    logic        walk_fault;
    logic        fault_clr = 1'b0;
    logic        fault_sticky;
    logic [31:0] fault_addr;

    always #10 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
        .base_err(base_err), .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .refill_valid(refill_valid), .refill_va(refill_va), .refill_pa(refill_pa),
        .refill_size(refill_size), .refill_attr(refill_attr), .walk_fault(walk_fault),
        .fault_clr(fault_clr), .fault_sticky(fault_sticky), .fault_addr(fault_addr)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mem [logic [31:0]];
    bit          stall_mode = 1'b0;
    int          rd_count = 0;
    logic [31:0] rd_addr0, rd_addr1;
    bit          got_ok, got_flt;
    logic [31:0] got_pa, got_va;
    logic [1:0]  got_sz;
    logic [9:0]  got_attr;

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model: response one cycle after acceptance
    initial begin
        bit          pend = 1'b0;
        logic [31:0] paddr = '0;
        int          cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd_mem(paddr);
                pend = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
            end
            mem_rd_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
            if (mem_rd_valid && mem_rd_ready) begin
                pend  = 1'b1;
                paddr = mem_rd_addr;
                if (rd_count == 0) rd_addr0 = mem_rd_addr;
                if (rd_count == 1) rd_addr1 = mem_rd_addr;
                rd_count++;
            end
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_walk(input logic [31:0] va);
        got_ok = 1'b0; got_flt = 1'b0;
        @(negedge clk);
        rd_count = 0;
        req_valid = 1'b1;
        req_va = va;
        for (int w = 0; w < 20 && !req_ready; w++) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int w = 0; w < 40; w++) begin
            if (refill_valid || walk_fault) break;
            @(negedge clk);
        end
        got_ok = refill_valid; got_flt = walk_fault;
        got_pa = refill_pa; got_sz = refill_size; got_attr = refill_attr; got_va = refill_va;
        if (!got_ok && !got_flt) chk("R11", "walk completion", 32'h0, 32'h1);
    endtask

    task automatic check_leaf(input string rq, input logic [31:0] va, input logic [31:0] pa,
                              input logic [1:0] sz, input logic [9:0] attr, input int nrd,
                              input logic [31:0] a1);
        do_walk(va);
        chk(rq, "refill seen", {31'h0, got_ok}, 32'h1);
        chk(rq, "pa", got_pa, pa);
        chk(rq, "size", {30'h0, got_sz}, {30'h0, sz});
        chk("R8", "attr", {22'h0, got_attr}, {22'h0, attr});
        chk("R8", "refill va", got_va, va);
        chk("R2", "read count", rd_count, nrd);
        chk("R2", "L1 address", rd_addr0, BASE + {18'h0, va[31:20], 2'b00});
        if (nrd == 2) chk("R3", "L2 address", rd_addr1, a1);
    endtask

    task automatic check_fault(input string rq, input logic [31:0] va);
        do_walk(va);
        chk(rq, "fault pulse", {31'h0, got_flt}, 32'h1);
        chk("R9", "no refill", {31'h0, got_ok}, 32'h0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        logic [31:0] va, d;
        logic [9:0]  at;

        // Table image
        for (int i = 0; i < 8; i++) begin
            at = 10'((i * 37 + 5) & 10'h3FF);
            mem[BASE + 32'((32'h100 + i) * 4)] = ((32'h800 + 32'(i * 3)) << 20) | ({22'h0, at} << 2) | 32'h2;
        end
        for (int c = 0; c < 16; c++)
            mem[BASE + 32'((32'h200 + c) * 4)] = 32'hA500_0000 | (32'h1 << 18) | (32'h2AA << 2) | 32'h2;
        mem[BASE + 32'h300 * 4] = L2BASE | 32'h1;
        mem[BASE + 32'h500 * 4] = 32'h1234_5673;
        for (int k = 0; k < 16; k++)
            mem[L2BASE + 32'(k * 4)] = 32'h7770_0000 | (32'h155 << 2) | 32'h1;
        for (int k = 16; k < 32; k++)
            mem[L2BASE + 32'(k * 4)] = ((32'h12300 + 32'(k)) << 12) | (32'(k * 11) << 2) | ((k % 2 == 1) ? 32'h3 : 32'h2);

        repeat (3) @(negedge clk);
        chk("R1", "reset req_ready", {31'h0, req_ready}, 32'h0);
        chk("R11", "reset refill_valid", {31'h0, refill_valid}, 32'h0);
        chk("R10", "reset sticky", {31'h0, fault_sticky}, 32'h0);
        chk("R2", "reset rd_valid", {31'h0, mem_rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_base = BASE; cfg_enable = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "aligned ready", {31'h0, req_ready}, 32'h1);
        chk("R1", "aligned base_err", {31'h0, base_err}, 32'h0);

        // R5 section sweep
        for (int i = 0; i < 8; i++) begin
            for (int o = 0; o < 3; o++) begin
                logic [31:0] off;
                off = (o == 0) ? 32'h0 : (o == 1) ? ((32'h12345 ^ 32'(i * 32'h1111)) & 32'hFFFFF) : 32'hFFFFF;
                va = ((32'h100 + 32'(i)) << 20) | off;
                at = 10'((i * 37 + 5) & 10'h3FF);
                check_leaf("R5", va, ((32'h800 + 32'(i * 3)) << 20) | off, 2'd2, at, 1, 32'h0);
            end
        end

        // R6 supersection: every copy
        for (int c = 0; c < 16; c++) begin
            va = ((32'h200 + 32'(c)) << 20) | (32'(c * 32'h3579) & 32'hFFFFF);
            check_leaf("R6", va, 32'hA500_0000 | (va & 32'h00FF_FFFF), 2'd3, 10'h2AA, 1, 32'h0);
        end

        // R7 large pages (every copy) and small pages, with and without stalls (R12)
        for (int pass = 0; pass < 2; pass++) begin
            stall_mode = (pass == 1);
            for (int k = 0; k < 32; k++) begin
                va = (32'h300 << 20) | (32'(k) << 12) | (32'(k * 32'h1F3) & 32'hFFF);
                if (k < 16)
                    check_leaf("R7", va, 32'h7770_0000 | (va & 32'hFFFF), 2'd1, 10'h155, 2, L2BASE + 32'(k * 4));
                else
                    check_leaf("R7", va, ((32'h12300 + 32'(k)) << 12) | (va & 32'hFFF), 2'd0,
                               10'(k * 11), 2, L2BASE + 32'(k * 4));
            end
        end
        stall_mode = 1'b0;

        // R4 / R9 / R10 faults
        check_fault("R4", 32'h4001_2345);
        chk("R2", "L1 fault reads", rd_count, 1);
        @(negedge clk);
        chk("R10", "sticky set", {31'h0, fault_sticky}, 32'h1);
        chk("R10", "fault addr", fault_addr, 32'h4001_2345);
        check_fault("R9", 32'h3002_8ABC);
        chk("R3", "L2 fault reads", rd_count, 2);
        @(negedge clk);
        chk("R10", "addr kept", fault_addr, 32'h4001_2345);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R10", "sticky cleared", {31'h0, fault_sticky}, 32'h0);
        check_fault("R4", 32'h5000_0010);
        @(negedge clk);
        chk("R10", "new fault addr", fault_addr, 32'h5000_0010);
        chk("R10", "sticky again", {31'h0, fault_sticky}, 32'h1);

        // R1 misaligned base rejected
        cfg_enable = 1'b0;
        @(negedge clk);
        cfg_base = BASE | 32'h2000; cfg_enable = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "base_err", {31'h0, base_err}, 32'h1);
        rd_count = 0;
        req_valid = 1'b1; req_va = 32'h1000_0000;
        repeat (6) begin
            @(negedge clk);
            chk("R1", "blocked ready", {31'h0, req_ready}, 32'h0);
        end
        req_valid = 1'b0;
        chk("R1", "no reads", rd_count, 0);

        done = 1'b1;
        finish_run();
    end

endmodule